// File: doc/BRIEF.md
# Dual Guarded Multiply-Accumulate Unit

This block is the accumulator side of a DSP datapath. It holds two independent accumulators, each a 64-bit body with an 8-bit guard byte above it. Every strobed operation takes two 32-bit sources, an accumulator select, an operation code, a form field and a shift count. The operation either loads or updates the selected accumulator, rounds it, or reads part of it back.

Products come in four forms. Three multiply two signed 16-bit lanes and shift the product left by 16. The fourth is a full signed 32x32 product with no shift. A product can replace the accumulator, be added to it, or be subtracted from it, and the guard byte takes the carry or the borrow. Rounding shifts the body, may add a half-word constant, and saturates to one of four limit pairs.

Reads come back on a registered 32-bit port one cycle after the request. Writes can replace one part of an accumulator and leave the rest as it was.

Top module: `dacc_unit`

## Requirements
- R1: After reset, both accumulators (body and guard) are zero, `res_valid` is 0 and `res_data` is 0.
- R2: An operation acts only when `op_valid` is 1, and only on the accumulator named by `acc_sel`; the other accumulator is untouched. Op codes: 1 load, 2 multiply-add, 3 multiply-subtract, 4 round, 5 read high, 6 read middle, 7 read low, 8 read guard, 9 write high, 10 write low, 11 write guard. Codes 0 and 12 to 15 change nothing and produce no read.
- R3: For load, add and subtract, `form` selects the product term. 0 is A[31:16]*B[31:16], 1 is A[15:0]*B[31:16] and 2 is A[15:0]*B[15:0]. Each of these is a signed 16x16 product shifted left by 16. 3 is the signed A*B product, 64 bits wide, with no shift.
- R4: Load writes the term into the body and fills the guard with the term's sign (0xFF if negative, 0x00 otherwise).
- R5: Multiply-add adds the sign-extended term to the 72-bit {guard, body}, so a carry out of the body increments the guard and a negative term without carry decrements it.
- R6: Multiply-subtract subtracts the sign-extended term from the 72-bit {guard, body}. The guard takes the borrow and wraps as a signed byte.
- R7: Round shifts the body left by the shift count. It then adds 0x80000000 for forms 0 and 2. It clamps signed against a limit pair: form 0 uses 0x00007FFF00000000 / 0xFFFF800000000000, form 1 uses 0x00007FFF00000000 / 0xFFFFFFFF80000000, form 2 uses 0x7FFFFFFF00000000 / 0xFFFFFFFF80000000, and form 3 uses 0x7FFFFFFF00000000 / 0xFFFF800000000000. An unclamped result has bits 31:0 cleared. The guard becomes the sign of the result.
- R8: Read high, middle and low return bits 63:32, 47:16 and 31:0 of the body shifted left by the shift count.
- R9: Read guard returns the sign-extended guard. For a shift count n of 1 or 2, the sign-extended guard is shifted left by n and the body's top n bits fill the vacated low bits.
- R10: Write high replaces body bits 63:32 with A. Write low replaces bits 31:0 with A. Write guard replaces the guard with A[7:0]. All other bits keep their value.
- R11: The shift count input is 2 bits wide; the value 3 acts as 0.
- R12: A read puts `res_valid` high and the value on `res_data` in the cycle after the request. In every other cycle `res_valid` is low and `res_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code (R2) |
| acc_sel | input | 1 | Target accumulator |
| form | input | 2 | Product form or rounding variant |
| shamt | input | 2 | Shift count for round and reads |
| src_a | input | 32 | Source operand A |
| src_b | input | 32 | Source operand B |
| res_valid | output | 1 | Read result valid |
| res_data | output | 32 | Read result |

## Verification
Accumulator state shows at the ports only through reads, so every update in the bench is followed by reads of the parts it could have changed. A wrong guard carry or borrow, a wrong lane, or a wrong clamp shows as a wrong word on the read that follows one cycle later. An update that reaches the wrong accumulator shows at the next read of the other one. Carry and borrow across the body, every rounding limit, and the shifted guard read are driven on purpose. A long random run then mixes all operations.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    localparam int WORD_W  = 32;
    localparam int BODY_W  = 64;
    localparam int GUARD_W = 8;
    localparam int ACC_W   = BODY_W + GUARD_W;
    localparam int HALF_W  = WORD_W / 2;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_LOAD  = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_RND   = 4'd4,
        OP_RD_HI = 4'd5,
        OP_RD_MI = 4'd6,
        OP_RD_LO = 4'd7,
        OP_RD_GU = 4'd8,
        OP_WR_HI = 4'd9,
        OP_WR_LO = 4'd10,
        OP_WR_GU = 4'd11
    } op_e;

    localparam logic [1:0] FORM_HH   = 2'd0;
    localparam logic [1:0] FORM_LH   = 2'd1;
    localparam logic [1:0] FORM_LL   = 2'd2;
    localparam logic [1:0] FORM_WORD = 2'd3;

    typedef struct packed {
        logic [GUARD_W-1:0] guard;
        logic [BODY_W-1:0]  body;
    } acc_t;
endpackage

// File: rtl/dacc_mul.sv
module dacc_mul
    import dacc_pkg::*;
(
    input  logic [1:0]        form,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic [BODY_W-1:0] term
);
    logic signed [HALF_W-1:0] lane_a;
    logic signed [HALF_W-1:0] lane_b;
    logic signed [WORD_W-1:0] half_prod;
    logic signed [BODY_W-1:0] word_prod;

    always_comb begin
        lane_a    = (form == FORM_HH) ? opa[WORD_W-1:HALF_W] : opa[HALF_W-1:0];
        lane_b    = (form == FORM_LL) ? opb[HALF_W-1:0] : opb[WORD_W-1:HALF_W];
        half_prod = $signed(WORD_W'(lane_a)) * $signed(WORD_W'(lane_b));
        word_prod = $signed(BODY_W'($signed(opa))) * $signed(BODY_W'($signed(opb)));
        if (form == FORM_WORD) begin
            term = word_prod;
        end else begin
            term = {{HALF_W{half_prod[WORD_W-1]}}, half_prod, {HALF_W{1'b0}}};
        end
    end
endmodule

// File: rtl/dacc_round.sv
module dacc_round
    import dacc_pkg::*;
(
    input  logic [BODY_W-1:0] body,
    input  logic [1:0]        variant,
    input  logic [1:0]        sh,
    output acc_t              result
);
    localparam logic [BODY_W-1:0] HALF_ULP  = 64'h0000_0000_8000_0000;
    localparam logic [BODY_W-1:0] POS_WORD  = 64'h0000_7FFF_0000_0000;
    localparam logic [BODY_W-1:0] POS_LONG  = 64'h7FFF_FFFF_0000_0000;
    localparam logic [BODY_W-1:0] NEG_WIDE  = 64'hFFFF_8000_0000_0000;
    localparam logic [BODY_W-1:0] NEG_NARR  = 64'hFFFF_FFFF_8000_0000;

    logic [BODY_W-1:0] shifted;
    logic [BODY_W-1:0] summed;
    logic [BODY_W-1:0] pos_lim;
    logic [BODY_W-1:0] neg_lim;
    logic [BODY_W-1:0] clamped;
    logic              use_add;

    always_comb begin
        case (variant)
            2'd0:    begin use_add = 1'b1; pos_lim = POS_WORD; neg_lim = NEG_WIDE; end
            2'd1:    begin use_add = 1'b0; pos_lim = POS_WORD; neg_lim = NEG_NARR; end
            2'd2:    begin use_add = 1'b1; pos_lim = POS_LONG; neg_lim = NEG_NARR; end
            default: begin use_add = 1'b0; pos_lim = POS_LONG; neg_lim = NEG_WIDE; end
        endcase
        shifted = body << sh;
        summed  = shifted + (use_add ? HALF_ULP : '0);
        if ($signed(summed) > $signed(pos_lim)) begin
            clamped = pos_lim;
        end else if ($signed(summed) < $signed(neg_lim)) begin
            clamped = neg_lim;
        end else begin
            clamped = {summed[BODY_W-1:WORD_W], {WORD_W{1'b0}}};
        end
        result.body  = clamped;
        result.guard = {GUARD_W{clamped[BODY_W-1]}};
    end
endmodule

// File: rtl/dacc_read.sv
module dacc_read
    import dacc_pkg::*;
(
    input  acc_t              acc,
    input  logic [3:0]        kind,
    input  logic [1:0]        sh,
    output logic [WORD_W-1:0] word
);
    logic [BODY_W-1:0] shifted;
    logic [WORD_W-1:0] guard_ext;

    always_comb begin
        shifted   = acc.body << sh;
        guard_ext = {{(WORD_W-GUARD_W){acc.guard[GUARD_W-1]}}, acc.guard};
        case (op_e'(kind))
            OP_RD_HI: word = shifted[BODY_W-1:WORD_W];
            OP_RD_MI: word = shifted[BODY_W-HALF_W-1:HALF_W];
            OP_RD_LO: word = shifted[WORD_W-1:0];
            OP_RD_GU: begin
                case (sh)
                    2'd1:    word = {guard_ext[WORD_W-2:0], acc.body[BODY_W-1]};
                    2'd2:    word = {guard_ext[WORD_W-3:0], acc.body[BODY_W-1:BODY_W-2]};
                    default: word = guard_ext;
                endcase
            end
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/dacc_unit.sv
module dacc_unit
    import dacc_pkg::*;
#(
    parameter int NUM_ACC = 2,
    localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic [1:0]        form,
    input  logic [1:0]        shamt,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_data
);
    typedef struct packed {
        acc_t [NUM_ACC-1:0] acc;
        logic               rd_valid;
        logic [WORD_W-1:0]  rd_data;
    } state_t;

    state_t state_d, state_q;

    logic [1:0]              sh_eff;
    acc_t                    cur_acc;
    acc_t                    rnd_out;
    acc_t                    new_acc;
    logic                    do_write;
    logic [BODY_W-1:0]       term;
    logic [ACC_W-1:0]        term_ext;
    logic [WORD_W-1:0]       rd_word;
    logic [NUM_ACC*ACC_W-1:0] acc_flat;

    assign sh_eff   = (shamt == 2'd3) ? 2'd0 : shamt;
    assign term_ext = {{GUARD_W{term[BODY_W-1]}}, term};

    always_comb begin
        cur_acc = '0;
        for (int i = 0; i < NUM_ACC; i++) begin
            if (acc_sel == SEL_W'(i)) cur_acc = state_q.acc[i];
        end
    end

    dacc_mul u_mul (
        .form (form),
        .opa  (src_a),
        .opb  (src_b),
        .term (term)
    );

    dacc_round u_round (
        .body    (cur_acc.body),
        .variant (form),
        .sh      (sh_eff),
        .result  (rnd_out)
    );

    dacc_read u_read (
        .acc  (cur_acc),
        .kind (op_code),
        .sh   (sh_eff),
        .word (rd_word)
    );

    always_comb begin
        state_d          = state_q;
        state_d.rd_valid = 1'b0;
        new_acc          = cur_acc;
        do_write         = 1'b0;
        if (op_valid) begin
            case (op_e'(op_code))
                OP_LOAD: begin new_acc = acc_t'(term_ext); do_write = 1'b1; end
                OP_ADD:  begin new_acc = acc_t'(cur_acc + term_ext); do_write = 1'b1; end
                OP_SUB:  begin new_acc = acc_t'(cur_acc - term_ext); do_write = 1'b1; end
                OP_RND:  begin new_acc = rnd_out; do_write = 1'b1; end
                OP_RD_HI, OP_RD_MI, OP_RD_LO, OP_RD_GU: begin
                    state_d.rd_valid = 1'b1;
                    state_d.rd_data  = rd_word;
                end
                OP_WR_HI: begin new_acc.body[BODY_W-1:WORD_W] = src_a; do_write = 1'b1; end
                OP_WR_LO: begin new_acc.body[WORD_W-1:0] = src_a; do_write = 1'b1; end
                OP_WR_GU: begin new_acc.guard = src_a[GUARD_W-1:0]; do_write = 1'b1; end
                default: ;
            endcase
        end
        if (do_write) begin
            for (int i = 0; i < NUM_ACC; i++) begin
                if (acc_sel == SEL_W'(i)) state_d.acc[i] = new_acc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign res_valid = state_q.rd_valid;
    assign res_data  = state_q.rd_data;
    assign acc_flat  = state_q.acc;
endmodule

// File: rtl/dacc_checker.sv
module dacc_checker
    import dacc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_valid,
    input logic [3:0]           op_code,
    input logic                 acc_sel,
    input logic [WORD_W-1:0]    src_a,
    input logic                 res_valid,
    input logic [WORD_W-1:0]    res_data,
    input logic [2*ACC_W-1:0]   acc_flat
);
    logic [ACC_W-1:0] a0;
    logic [ACC_W-1:0] a1;
    logic             is_rd;
    logic             on0;

    assign a0    = acc_flat[ACC_W-1:0];
    assign a1    = acc_flat[2*ACC_W-1:ACC_W];
    assign is_rd = op_valid && (op_code >= 4'(OP_RD_HI)) && (op_code <= 4'(OP_RD_GU));
    assign on0   = op_valid && !acc_sel;

    AST_OTHER0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && acc_sel) |=> $stable(a0)); // R2
    AST_OTHER1_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel) |=> $stable(a1)); // R2
    AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_flat) && !res_valid)); // R2
    AST_LOAD_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (on0 && op_code == 4'(OP_LOAD)) |=> (a0[ACC_W-1:BODY_W] == {GUARD_W{a0[BODY_W-1]}})); // R4
    AST_ROUND_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (on0 && op_code == 4'(OP_RND)) |=> (a0[ACC_W-1:BODY_W] == {GUARD_W{a0[BODY_W-1]}})); // R7
    AST_ROUND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (on0 && op_code == 4'(OP_RND)) |=> (a0[WORD_W-1:0] == 32'h0 || a0[WORD_W-1:0] == 32'h8000_0000)); // R7
    AST_WRHI_PART: assert property (@(posedge clk) disable iff (!rst_n)
        (on0 && op_code == 4'(OP_WR_HI)) |=> (a0[BODY_W-1:WORD_W] == $past(src_a)
            && $stable(a0[WORD_W-1:0]) && $stable(a0[ACC_W-1:BODY_W]))); // R10
    AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> res_valid); // R12
    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> (!res_valid && $stable(res_data))); // R12
endmodule

bind dacc_unit dacc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .acc_sel   (acc_sel),
    .src_a     (src_a),
    .res_valid (res_valid),
    .res_data  (res_data),
    .acc_flat  (acc_flat)
);

// File: tb/dacc_unit_bench.sv
module dacc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        acc_sel = 1'b0;
    logic [1:0]  form = '0;
    logic [1:0]  shamt = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        res_valid;
    logic [31:0] res_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [71:0] m_acc [2];

    always #5 clk = ~clk;

    dacc_unit u_dacc_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_sel(acc_sel), .form(form), .shamt(shamt), .src_a(src_a),
        .src_b(src_b), .res_valid(res_valid), .res_data(res_data)
    );

    function automatic logic [63:0] m_term(input logic [1:0] f, input logic [31:0] a, input logic [31:0] b);
        longint x, y;
        case (f)
            2'd0: begin x = longint'($signed(a[31:16])); y = longint'($signed(b[31:16])); end
            2'd1: begin x = longint'($signed(a[15:0]));  y = longint'($signed(b[31:16])); end
            2'd2: begin x = longint'($signed(a[15:0]));  y = longint'($signed(b[15:0]));  end
            default: begin x = longint'($signed(a)); y = longint'($signed(b)); end
        endcase
        return (f == 2'd3) ? 64'(x * y) : 64'((x * y) * 65536);
    endfunction

    function automatic logic [63:0] m_round(input logic [63:0] body, input logic [1:0] v, input logic [1:0] n);
        longint t, hi, lo;
        t = longint'(body << n);
        if (v == 2'd0 || v == 2'd2) t = t + 64'h8000_0000;
        hi = (v < 2'd2) ? 64'h0000_7FFF_0000_0000 : 64'h7FFF_FFFF_0000_0000;
        lo = (v == 2'd1 || v == 2'd2) ? 64'hFFFF_FFFF_8000_0000 : 64'hFFFF_8000_0000_0000;
        if (t > hi) return 64'(hi);
        if (t < lo) return 64'(lo);
        return 64'(t) & 64'hFFFF_FFFF_0000_0000;
    endfunction

    task automatic note_fail(input string tag, input logic [31:0] act, input logic [31:0] exp);
        errors++;
        $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    endtask

    task automatic issue(input logic [3:0] op, input logic sel, input logic [1:0] f,
                         input logic [1:0] n, input logic [31:0] a, input logic [31:0] b,
                         input string tag);
        logic [1:0]  ne;
        logic [63:0] t, body;
        logic [31:0] gx, rdv;
        ne = (n == 2'd3) ? 2'd0 : n;
        body = m_acc[sel][63:0];
        gx = {{24{m_acc[sel][71]}}, m_acc[sel][71:64]};
        t = m_term(f, a, b);
        op_valid = 1'b1; op_code = op; acc_sel = sel; form = f; shamt = n; src_a = a; src_b = b;
        case (op)
            4'd1: m_acc[sel] = {{8{t[63]}}, t};
            4'd2: m_acc[sel] = m_acc[sel] + {{8{t[63]}}, t};
            4'd3: m_acc[sel] = m_acc[sel] - {{8{t[63]}}, t};
            4'd4: begin t = m_round(body, f, ne); m_acc[sel] = {{8{t[63]}}, t}; end
            4'd9:  m_acc[sel][63:32] = a;
            4'd10: m_acc[sel][31:0] = a;
            4'd11: m_acc[sel][71:64] = a[7:0];
            default: ;
        endcase
        if (op >= 4'd5 && op <= 4'd8) begin
            t = body << ne;
            case (op)
                4'd5: rdv = t[63:32];
                4'd6: rdv = t[47:16];
                4'd7: rdv = t[31:0];
                default: rdv = (ne == 2'd1) ? {gx[30:0], body[63]} :
                               (ne == 2'd2) ? {gx[29:0], body[63:62]} : gx;
            endcase
            exp_q.push_back(rdv);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic read_all(input logic sel, input string tag);
        for (int k = 5; k <= 8; k++) issue(4'(k), sel, 2'd0, 2'd0, '0, '0, tag);
    endtask

    task automatic set_acc(input logic sel, input logic [7:0] g, input logic [63:0] v);
        issue(4'd9, sel, 2'd0, 2'd0, v[63:32], '0, "R10");
        issue(4'd10, sel, 2'd0, 2'd0, v[31:0], '0, "R10");
        issue(4'd11, sel, 2'd0, 2'd0, {24'h0, g}, '0, "R10");
    endtask

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                note_fail("R12 unexpected read", res_data, 32'h0);
            end else begin
                logic [31:0] e;
                string tg;
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                if (res_data !== e) note_fail(tg, res_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %08h expected %08h", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_acc[0] = '0; m_acc[1] = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_data !== 32'h0) note_fail("R1 reset outputs", {31'h0, res_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        read_all(1'b0, "R1"); read_all(1'b1, "R1");
        // R3 R4: lane forms on acc0, full word on acc1
        issue(4'd1, 1'b0, 2'd0, 2'd0, 32'h8000_1234, 32'h7FFF_0002, "R3"); read_all(1'b0, "R3 R4 hh");
        issue(4'd1, 1'b0, 2'd1, 2'd0, 32'h8000_F234, 32'h7FFF_0002, "R3"); read_all(1'b0, "R3 R4 lh");
        issue(4'd1, 1'b0, 2'd2, 2'd0, 32'h0001_FFFF, 32'h7FFF_0003, "R3"); read_all(1'b0, "R3 R4 ll");
        issue(4'd1, 1'b1, 2'd3, 2'd0, 32'h8000_0000, 32'h7FFF_FFFF, "R3"); read_all(1'b1, "R3 R4 word");
        read_all(1'b0, "R2 isolation");
        // R2: inert codes
        issue(4'd13, 1'b0, 2'd3, 2'd0, 32'h1, 32'h1, "R2");
        issue(4'd0, 1'b1, 2'd3, 2'd0, 32'h1, 32'h1, "R2");
        read_all(1'b0, "R2 inert"); read_all(1'b1, "R2 inert");
        // R5 carry into guard
        set_acc(1'b0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
        issue(4'd2, 1'b0, 2'd3, 2'd0, 32'h1, 32'h1, "R5"); read_all(1'b0, "R5 carry");
        issue(4'd2, 1'b0, 2'd3, 2'd0, 32'hFFFF_FFFF, 32'h2, "R5"); read_all(1'b0, "R5 borrow");
        // R6 borrow from zero
        set_acc(1'b1, 8'h00, 64'h0);
        issue(4'd3, 1'b1, 2'd3, 2'd0, 32'h1, 32'h1, "R6"); read_all(1'b1, "R6 borrow");
        issue(4'd3, 1'b1, 2'd0, 2'd0, 32'h8000_0000, 32'h7FFF_0000, "R6"); read_all(1'b1, "R6 lanes");
        set_acc(1'b1, 8'h80, 64'h0);
        issue(4'd3, 1'b1, 2'd3, 2'd0, 32'h1, 32'h1, "R6"); read_all(1'b1, "R6 wrap");
        // R7 all variants, positive/negative/in-range, with shifts
        for (int v = 0; v < 4; v++) begin
            set_acc(1'b0, 8'h00, 64'h4000_0000_0000_0000);
            issue(4'd4, 1'b0, 2'(v), 2'd0, '0, '0, "R7"); read_all(1'b0, "R7 pos clamp");
            set_acc(1'b0, 8'hFF, 64'hC000_0000_0000_0000);
            issue(4'd4, 1'b0, 2'(v), 2'd1, '0, '0, "R7"); read_all(1'b0, "R7 neg clamp");
            set_acc(1'b0, 8'h00, 64'h0000_1234_8000_0001);
            issue(4'd4, 1'b0, 2'(v), 2'd2, '0, '0, "R7"); read_all(1'b0, "R7 in range");
        end
        // R8 R9 R11 shifted reads
        set_acc(1'b1, 8'h01, 64'h8123_4567_89AB_CDEF);
        for (int n = 0; n < 4; n++)
            for (int k = 5; k <= 8; k++) issue(4'(k), 1'b1, 2'd0, 2'(n), '0, '0, (n == 3) ? "R11" : "R8 R9");
        set_acc(1'b1, 8'hFE, 64'h4000_0000_0000_0000);
        issue(4'd8, 1'b1, 2'd0, 2'd2, '0, '0, "R9"); issue(4'd8, 1'b1, 2'd0, 2'd1, '0, '0, "R9");
        // R10 partial writes
        issue(4'd10, 1'b1, 2'd0, 2'd0, 32'hDEAD_BEEF, '0, "R10"); read_all(1'b1, "R10 low");
        issue(4'd11, 1'b1, 2'd0, 2'd0, 32'hFFFF_FF5A, '0, "R10"); read_all(1'b1, "R10 guard");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            issue(4'($urandom_range(0, 15)), 1'($urandom), 2'($urandom), 2'($urandom),
                  $urandom, $urandom, "R5 R6 R8 random");
        end
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) note_fail("R12 missing reads", 32'(exp_q.size()), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule